// File: doc/BRIEF.md
# Zero-IF Tuner Control Register Slave

This block is the serial control port of a zero-IF satellite tuner. It sits on a two-wire I2C bus as a slave. It holds the tuner's control settings and presents every decoded field on parallel outputs to the analog sections:

- the two PLL divider words and the prescaler and reference-divider selects,
- the VCO band code and the charge-pump current code,
- the baseband gain code and the baseband low-pass bandwidth code,
- the test-mode flag.

A host programs the tuner with one fixed write frame: the address byte followed by four control bytes. The four control bytes are staged internally and reach the outputs together. A read frame returns one status byte first. Further bytes, if the host keeps acknowledging, return the committed control bytes.

SCL and SDA are sampled by the block clock through a synchronizer. SDA is open-drain, modelled as an input, a constant-low output and an output enable. The two-bit address-select pin picks one of four device addresses.

Top module: `tuner_ctl_i2c`

## Requirements
- R1: The 8-bit write address is C0h + 2·addr_sel_i (C0h, C2h, C4h, C6h) and the read address is that value + 1. The block acknowledges only its own address. For any other address it never drives SDA, and nothing changes.
- R2: A write frame is START, address, then four control bytes. The fields are mapped as follows:
  - byte 0 = n_div[7:0].
  - byte 1 = {a_div[4:0], psc_sel, ref_sel, test_mode} (MSB first).
  - byte 2 = {vco_band[3:0], cp_code[1:0], bb_gain[1:0]}.
  - byte 3 = {lpf_bw[3:0], four stored reserved bits}.
- R3: The outputs keep their previous values until the fourth control byte (the fifth byte of the frame) is acknowledged. All fields then change together.
- R4: A STOP or a repeated START before the fourth control byte discards the partial frame. The outputs are unchanged.
- R5: Every byte after the fourth control byte is not acknowledged and changes nothing.
- R6: The first byte of a read is the status byte: bit 7 = power-on flag (por_i), bit 6 = PLL lock flag (pll_lock_i), bits 5:0 = 0.
- R7: While the host acknowledges, later read bytes return control bytes 0, 1, 2 and 3 in order, then FFh. A host NACK ends the read, and SDA is released.
- R8: After reset, all control fields are 0 except cp_code = 11b. Byte 2 therefore reads back as 0Ch. SDA is not driven.
- R9: The SDA drive changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_o | output | 1 | Data value driven when enabled (always 0) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_sel_i | input | 2 | Hardware address select |
| por_i | input | 1 | Supply-below-threshold flag for status |
| pll_lock_i | input | 1 | PLL lock flag for status |
| n_div_o | output | 8 | Main divider word |
| a_div_o | output | 5 | Swallow divider word |
| psc_sel_o | output | 1 | Prescaler select (1 = divide by 16, 0 = by 32) |
| ref_sel_o | output | 1 | Reference divider select (0 = by 4, 1 = by 8) |
| vco_band_o | output | 4 | VCO band code |
| cp_code_o | output | 2 | Charge-pump current code |
| bb_gain_o | output | 2 | Baseband gain code |
| lpf_bw_o | output | 4 | Baseband low-pass bandwidth code |
| test_mode_o | output | 1 | Test-mode flag |

## Verification
Assertions check three rules on every cycle:

- the output registers stay frozen except on the commit cycle;
- staging never accepts more control bytes than the frame holds;
- the slave never drives SDA while idle, and changes its drive only while SCL is low.

Address decoding for all four select codes, abort by STOP and by repeated START, rejection of a sixth byte, and the status and read-back sequence can only be shown by bench scenarios. In those scenarios the bench's own bus master drives the frames. A behavioural model of the register contents is compared against the outputs on every clock.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam int unsigned CTL_BYTES = 4;
  localparam int unsigned CTL_W     = CTL_BYTES * 8;
  localparam int unsigned RD_IDX_W  = $clog2(CTL_BYTES + 2);
  localparam int unsigned RD_TAB    = 1 << RD_IDX_W;
  // byte 2 default: charge pump at highest current
  localparam logic [CTL_W-1:0] CTL_RST = {8'h00, 8'h0C, 8'h00, 8'h00};

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK
  } link_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sh, sda_sh;
  logic         scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[MSB-1:0], scl_i};
      sda_sh <= {sda_sh[MSB-1:0], sda_i};
      scl_q  <= scl_sh[MSB];
      sda_q  <= sda_sh[MSB];
    end
  end

  assign scl_o      = scl_sh[MSB];
  assign sda_o      = sda_sh[MSB];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_slave_link.sv
module i2c_slave_link
  import tuner_i2c_pkg::*;
#(
  parameter int unsigned MAX_DATA = CTL_BYTES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                scl_rise_i,
  input  logic                scl_fall_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [6:0]          dev_addr_i,
  input  logic [7:0]          rd_byte_i,
  output logic [RD_IDX_W-1:0] rd_idx_o,
  output logic                frame_start_o,
  output logic                wr_valid_o,
  output logic [7:0]          wr_data_o,
  output logic                sda_oe_o
);
  localparam logic [RD_IDX_W-1:0] RD_LAST  = RD_IDX_W'(MAX_DATA + 1);
  localparam logic [RD_IDX_W-1:0] DATA_MAX = RD_IDX_W'(MAX_DATA);

  link_st_e            state;
  logic [7:0]          sr;
  logic [3:0]          bit_cnt;
  logic                is_addr, rnw, host_ack;
  logic [RD_IDX_W-1:0] data_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state         <= ST_IDLE;
      sr            <= '0;
      bit_cnt       <= '0;
      is_addr       <= 1'b0;
      rnw           <= 1'b0;
      host_ack      <= 1'b0;
      data_idx      <= '0;
      rd_idx_o      <= '0;
      frame_start_o <= 1'b0;
      wr_valid_o    <= 1'b0;
      wr_data_o     <= '0;
      sda_oe_o      <= 1'b0;
    end else begin
      frame_start_o <= 1'b0;
      wr_valid_o    <= 1'b0;
      if (start_i) begin
        state    <= ST_RX;
        bit_cnt  <= '0;
        is_addr  <= 1'b1;
        data_idx <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise_i) begin
              sr      <= {sr[6:0], sda_i};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall_i && bit_cnt == 4'd8) begin
              if (is_addr) begin
                if (sr[7:1] == dev_addr_i) begin
                  sda_oe_o      <= 1'b1;
                  rnw           <= sr[0];
                  is_addr       <= 1'b0;
                  rd_idx_o      <= '0;
                  frame_start_o <= ~sr[0];
                  state         <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (data_idx < DATA_MAX) begin
                sda_oe_o   <= 1'b1;
                wr_valid_o <= 1'b1;
                wr_data_o  <= sr;
                data_idx   <= data_idx + 1'b1;
                state      <= ST_ACK;
              end else begin
                state <= ST_IDLE;  // extra byte: NACK
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bit_cnt <= '0;
              if (rnw) begin
                sr       <= rd_byte_i;
                sda_oe_o <= ~rd_byte_i[7];
                if (rd_idx_o != RD_LAST) rd_idx_o <= rd_idx_o + 1'b1;
                state    <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bit_cnt == 4'd7) begin
                sda_oe_o <= 1'b0;
                state    <= ST_RACK;
              end else begin
                sr       <= {sr[6:0], 1'b0};
                sda_oe_o <= ~sr[6];
                bit_cnt  <= bit_cnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              host_ack <= ~sda_i;
            end else if (scl_fall_i) begin
              if (host_ack) begin
                bit_cnt  <= '0;
                sr       <= rd_byte_i;
                sda_oe_o <= ~rd_byte_i[7];
                if (rd_idx_o != RD_LAST) rd_idx_o <= rd_idx_o + 1'b1;
                state    <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: drive edges only inside SCL low
  p_drive_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  // R1: idle slave never touches the bus
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe_o);
endmodule

// File: rtl/tuner_ctl_bank.sv
module tuner_ctl_bank
  import tuner_i2c_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_data_i,
  output logic [CTL_W-1:0] ctl_o
);
  localparam int unsigned                  LAST   = CTL_BYTES - 1;
  localparam logic [RD_IDX_W-1:0]          LAST_C = RD_IDX_W'(LAST);

  logic [RD_IDX_W-1:0] stage_cnt;
  logic [7:0]          stage_q [LAST];
  logic                commit;

  assign commit = wr_valid_i && (stage_cnt == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            stage_cnt <= '0;
    else if (frame_start_i) stage_cnt <= '0;
    else if (wr_valid_i)    stage_cnt <= stage_cnt + 1'b1;
  end

  for (genvar g = 0; g < LAST; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        stage_q[g] <= '0;
      else if (wr_valid_i && stage_cnt == RD_IDX_W'(g))
        stage_q[g] <= wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ctl_o[g*8 +: 8] <= CTL_RST[g*8 +: 8];
      else if (commit) ctl_o[g*8 +: 8] <= stage_q[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_o[LAST*8 +: 8] <= CTL_RST[LAST*8 +: 8];
    else if (commit) ctl_o[LAST*8 +: 8] <= wr_data_i;
  end

  // R3: outputs frozen except on the commit cycle
  p_hold_until_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(ctl_o));

  // R5: link never delivers more bytes than the frame holds
  p_stage_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |-> (stage_cnt <= LAST_C));
endmodule

// File: rtl/tuner_ctl_i2c.sv
module tuner_ctl_i2c
  import tuner_i2c_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  BASE_ADDR7  = 7'h60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       sda_oe_o,
  input  logic [1:0] addr_sel_i,
  input  logic       por_i,
  input  logic       pll_lock_i,
  output logic [7:0] n_div_o,
  output logic [4:0] a_div_o,
  output logic       psc_sel_o,
  output logic       ref_sel_o,
  output logic [3:0] vco_band_o,
  output logic [1:0] cp_code_o,
  output logic [1:0] bb_gain_o,
  output logic [3:0] lpf_bw_o,
  output logic       test_mode_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic frame_start, wr_valid;
  logic [7:0] wr_data, rd_byte;
  logic [RD_IDX_W-1:0] rd_idx;
  logic [CTL_W-1:0] ctl;
  logic [7:0] rd_tab [RD_TAB];
  logic [6:0] dev_addr;

  assign dev_addr = BASE_ADDR7 + {5'd0, addr_sel_i};
  assign sda_o    = 1'b0;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  i2c_slave_link #(.MAX_DATA(CTL_BYTES)) i_link (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(bus_start), .stop_i(bus_stop),
    .dev_addr_i(dev_addr), .rd_byte_i(rd_byte), .rd_idx_o(rd_idx),
    .frame_start_o(frame_start), .wr_valid_o(wr_valid), .wr_data_o(wr_data),
    .sda_oe_o
  );

  tuner_ctl_bank i_bank (
    .clk_i, .rst_ni, .frame_start_i(frame_start),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .ctl_o(ctl)
  );

  // read sequence: status, control bytes, then all-ones
  for (genvar g = 0; g < RD_TAB; g++) begin : g_rd
    if (g == 0) begin : g_stat
      assign rd_tab[g] = {por_i, pll_lock_i, 6'd0};
    end else if (g <= CTL_BYTES) begin : g_ctl
      assign rd_tab[g] = ctl[(g-1)*8 +: 8];
    end else begin : g_pad
      assign rd_tab[g] = 8'hFF;
    end
  end
  assign rd_byte = rd_tab[rd_idx];

  assign n_div_o     = ctl[7:0];
  assign a_div_o     = ctl[15:11];
  assign psc_sel_o   = ctl[10];
  assign ref_sel_o   = ctl[9];
  assign test_mode_o = ctl[8];
  assign vco_band_o  = ctl[23:20];
  assign cp_code_o   = ctl[19:18];
  assign bb_gain_o   = ctl[17:16];
  assign lpf_bw_o    = ctl[31:28];
endmodule

// File: tb/test_tuner_ctl_i2c.sv
module test_tuner_ctl_i2c;
  localparam int Q = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic por = 1'b0, lock = 1'b0;
  logic sda_o, sda_oe;
  logic [7:0] n_div; logic [4:0] a_div; logic psc, refs, test;
  logic [3:0] vco, lpf; logic [1:0] cp, gain;
  wire bus_sda = sda_m & ~(sda_oe & ~sda_o);

  int total = 0, bad = 0, mon_bad = 0;
  logic settle = 1'b1;
  logic [7:0] exp_b [4];

  always #2.5 clk = ~clk;

  tuner_ctl_i2c i_tuner_ctl_i2c (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
    .sda_o(sda_o), .sda_oe_o(sda_oe), .addr_sel_i(addr_sel),
    .por_i(por), .pll_lock_i(lock),
    .n_div_o(n_div), .a_div_o(a_div), .psc_sel_o(psc), .ref_sel_o(refs),
    .vco_band_o(vco), .cp_code_o(cp), .bb_gain_o(gain), .lpf_bw_o(lpf),
    .test_mode_o(test)
  );

  // packed view of outputs in the byte layout of R2
  function automatic logic [27:0] outs();
    return {lpf, vco, cp, gain, a_div, psc, refs, test, n_div};
  endfunction
  function automatic logic [27:0] model();
    return {exp_b[3][7:4], exp_b[2], exp_b[1], exp_b[0]};
  endfunction

  // per-clock comparison against the model (R3/R4/R5)
  always @(negedge clk)
    if (rst_n && !settle && outs() !== model()) mon_bad++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask
  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~bus_sda; wq(); scl_m = 1'b0; wq();
  endtask
  task automatic recv_byte(input bit m_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1'b1; wq(); d = {d[6:0], bus_sda}; wq(); scl_m = 1'b0;
    end
    sda_m = ~m_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  // full five-byte frame; model updated once the last byte is acknowledged
  task automatic write_frame(input logic [7:0] adr, input logic [7:0] d0, d1, d2, d3, input string tag);
    logic ack; logic [7:0] d [4];
    d = '{d0, d1, d2, d3};
    i2c_start();
    send_byte(adr, ack); chk(ack, {tag, " addr ack"}, ack, 1);
    for (int k = 0; k < 4; k++) begin
      if (k == 3) settle = 1'b1;
      send_byte(d[k], ack); chk(ack, {tag, " data ack"}, ack, 1);
    end
    exp_b = d;
    settle = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic ack; logic [7:0] rd;
    exp_b = '{8'h00, 8'h00, 8'h0C, 8'h00};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk(outs() === model(), "R8 reset fields", {4'h0, outs()}, {4'h0, model()});
    chk(cp == 2'b11, "R8 cp default", cp, 2'b11);
    chk(!sda_oe, "R8 sda released", sda_oe, 0);
    settle = 1'b0;

    // R1/R2 frame at C0h with select 0
    write_frame(8'hC0, 8'h5A, 8'hB6, 8'h79, 8'hA5, "R1");
    i2c_stop();
    chk(n_div == 8'h5A && a_div == 5'd22, "R2 dividers", {n_div, 3'b0, a_div}, {8'h5A, 8'd22});
    chk(psc && refs && !test, "R2 selects", {psc, refs, test}, 3'b110);
    chk(vco == 4'h7 && cp == 2'b10 && gain == 2'b01 && lpf == 4'hA, "R2 analog codes",
        {vco, cp, gain, lpf}, {4'h7, 2'b10, 2'b01, 4'hA});

    // R3: partial frame leaves outputs untouched, last byte commits
    i2c_start(); send_byte(8'hC0, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
    chk(n_div == 8'h5A, "R3 hold mid-frame", n_div, 8'h5A);
    settle = 1'b1; send_byte(8'h44, ack);
    exp_b = '{8'h11, 8'h22, 8'h33, 8'h44}; settle = 1'b0;
    chk(ack && n_div == 8'h11 && lpf == 4'h4, "R3 commit on fifth byte", {n_div, lpf}, {8'h11, 4'h4});
    i2c_stop();

    // R4: abort by stop, then by repeated start
    i2c_start(); send_byte(8'hC0, ack); send_byte(8'hFF, ack); send_byte(8'hFF, ack); i2c_stop();
    chk(n_div == 8'h11 && a_div == 5'd4, "R4 stop abort", {n_div, 3'b0, a_div}, {8'h11, 8'd4});
    i2c_start(); send_byte(8'hC0, ack); send_byte(8'h77, ack); send_byte(8'h88, ack); send_byte(8'h99, ack);
    i2c_start(); send_byte(8'hC0, ack); send_byte(8'h66, ack); i2c_stop();
    chk(outs() === model(), "R4 restart abort", {4'h0, outs()}, {4'h0, model()});

    // R1: foreign addresses are ignored
    i2c_start(); send_byte(8'hC2, ack); i2c_stop();
    chk(!ack, "R1 nack C2h at select 0", ack, 0);
    i2c_start(); send_byte(8'hC4, ack); send_byte(8'h00, ack); i2c_stop();
    chk(!ack && !sda_oe && n_div == 8'h11, "R1 no effect C4h at select 0", {ack, n_div}, {1'b0, 8'h11});

    // R1 select 2 -> C4h
    addr_sel = 2'd2; wq();
    write_frame(8'hC4, 8'h3C, 8'h08, 8'hE4, 8'h30, "R1 sel2");
    i2c_stop();
    chk(n_div == 8'h3C && a_div == 5'd1 && vco == 4'hE && cp == 2'b01, "R1 sel2 fields",
        {n_div, a_div, vco, cp}, {8'h3C, 5'd1, 4'hE, 2'b01});

    // R5: sixth byte refused
    write_frame(8'hC4, 8'h10, 8'h01, 8'h8C, 8'h50, "R5");
    send_byte(8'hFE, ack);
    chk(!ack, "R5 sixth byte nack", ack, 0);
    i2c_stop();
    chk(n_div == 8'h10 && test && cp == 2'b11 && lpf == 4'h5, "R5 fields kept",
        {n_div, test, cp, lpf}, {8'h10, 1'b1, 2'b11, 4'h5});

    // R6 status byte
    por = 1'b1; lock = 1'b0; wq();
    i2c_start(); send_byte(8'hC5, ack); recv_byte(1'b0, rd); i2c_stop();
    chk(ack && rd == 8'h80, "R6 status por", rd, 8'h80);
    por = 1'b0; lock = 1'b1; wq();
    i2c_start(); send_byte(8'hC5, ack); recv_byte(1'b0, rd); i2c_stop();
    chk(rd == 8'h40, "R6 status lock", rd, 8'h40);

    // R7 read-back sequence
    i2c_start(); send_byte(8'hC5, ack);
    recv_byte(1'b1, rd); chk(rd == 8'h40, "R7 byte0 status", rd, 8'h40);
    for (int k = 0; k < 4; k++) begin
      recv_byte(1'b1, rd); chk(rd == exp_b[k], "R7 control readback", rd, exp_b[k]);
    end
    recv_byte(1'b0, rd); chk(rd == 8'hFF, "R7 pad byte", rd, 8'hFF);
    wq();
    chk(!sda_oe, "R7 R9 released after nack", sda_oe, 0);
    i2c_stop();

    // R1: read at wrong address
    i2c_start(); send_byte(8'hC1, ack); i2c_stop();
    chk(!ack, "R1 nack C1h at select 2", ack, 0);

    // R8 default readback via fresh reset
    settle = 1'b1; rst_n = 1'b0; wq(); rst_n = 1'b1; wq();
    exp_b = '{8'h00, 8'h00, 8'h0C, 8'h00}; settle = 1'b0;
    i2c_start(); send_byte(8'hC5, ack); recv_byte(1'b1, rd);
    recv_byte(1'b1, rd); recv_byte(1'b1, rd); recv_byte(1'b0, rd); i2c_stop();
    chk(rd == 8'h0C, "R8 byte2 readback", rd, 8'h0C);

    chk(mon_bad == 0, "R3 R4 R5 per-clock model", mon_bad, 0);
    finish_run();
  end
endmodule